// File: doc/BRIEF.md
# Mailbox Command Responder

This block is the device-side engine behind a byte-wide host mailbox. The host loads a 16-bit argument into two outgoing bytes, then writes a command code into a third outgoing byte. That write starts execution. The block decodes the code and performs a register write or a readback. It then publishes a 16-bit reply on two incoming bytes and copies the command code into an incoming echo byte. When the echo equals the code the host issued, the host knows the command has finished.

A dedicated clear command sets the echo back to zero. Without it, a command identical to the previous one could not be told apart from its predecessor. A fourth incoming byte mirrors an 8-bit digital input port. That port is synchronised and then sampled on a fixed period.

The supported operations are:
- driving and reading back the 8-bit output port;
- reading the firmware and hardware version words;
- storing 16-bit configuration words into a small table;
- a status read that returns the value last stored by a named command.

Every command completes a fixed, parameterised number of clock cycles after its code byte is written. That number must be chosen so that it stays under 250 microseconds at the chosen clock.

Top module: `mbox_responder`

## Requirements
- R1: After reset, the echo byte, both reply bytes, the output port and the input mirror are all zero.
- R2: A write to outgoing byte address 2 starts a command. The echo and reply change exactly LATENCY clock cycles after that write edge, and stay unchanged at every other time. The echo then equals the command code.
- R3: The argument is taken from byte addresses 0 (low) and 1 (high) as they hold at the moment the code is written. Argument writes made while the command runs do not affect it. Writes to byte address 3 have no effect.
- R4: Code 0x01 sets the output port to argument bits 7:0 and replies 0x00 followed by the new port value. No other code changes the output port.
- R5: Code 0x02 replies 0x00 followed by the current port value, and leaves the port unchanged.
- R6: Code 0x0E replies FW_VERSION and code 0x0F replies HW_VERSION.
- R7: A code in the range CFG_BASE to CFG_BASE+2^CFG_AW-1 (0x10 to 0x4F by default) stores its full 16-bit argument in a table entry for that code, and replies zero.
- R8: Code 0x07 treats argument bits 7:0 as a target code. If the target is a table code, the reply is the value last stored for it. If the target is 0x01 or 0x02, the reply is 0x00 followed by the output port. Any other target gives a zero reply.
- R9: Code 0x00 sets the echo to 0x00 and replies zero.
- R10: Any other code still echoes on time and replies zero.
- R11: The input mirror shows the input port after a two-flop synchroniser. It updates only once every SAMPLE_CYCLES cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr_en | input | 1 | Host write strobe for an outgoing byte |
| host_wr_addr | input | 2 | Outgoing byte address: 0 argument low, 1 argument high, 2 command code, 3 unused |
| host_wr_data | input | 8 | Byte written by the host |
| din_raw | input | IN_W | Asynchronous digital input port |
| dout | output | 8 | Output port state |
| ib_fb_lo | output | 8 | Reply low byte |
| ib_fb_hi | output | 8 | Reply high byte |
| ib_echo | output | 8 | Code of the last completed command |
| ib_din | output | IN_W | Sampled input port mirror |

## Verification
Some properties are checked by the assertions on every cycle:
- the echo and reply move only at completion, and exactly LATENCY cycles after the code write;
- the echo then carries the executed code;
- the clear and firmware-version replies have the required values;
- the output port moves only on code 0x01;
- the input mirror moves only on a sample tick.

Other behaviour can only be shown by the bench's scenarios:
- the decoded values of each command, including table writes followed by status reads of them;
- argument bytes overwritten while a command runs;
- writes to byte address 3;
- the clear command placed between identical commands, so that the repeat can be detected;
- unknown codes in and out of the table range.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam logic [7:0] OP_CLEAR   = 8'h00;
  localparam logic [7:0] OP_SET_OUT = 8'h01;
  localparam logic [7:0] OP_GET_OUT = 8'h02;
  localparam logic [7:0] OP_STATUS  = 8'h07;
  localparam logic [7:0] OP_FW_VER  = 8'h0E;
  localparam logic [7:0] OP_HW_VER  = 8'h0F;

  typedef enum logic [2:0] {
    K_CLEAR, K_SET_OUT, K_GET_OUT, K_STATUS, K_FW, K_HW, K_OTHER
  } op_kind_e;

  function automatic op_kind_e classify(input logic [7:0] code);
    case (code)
      OP_CLEAR:   return K_CLEAR;
      OP_SET_OUT: return K_SET_OUT;
      OP_GET_OUT: return K_GET_OUT;
      OP_STATUS:  return K_STATUS;
      OP_FW_VER:  return K_FW;
      OP_HW_VER:  return K_HW;
      default:    return K_OTHER;
    endcase
  endfunction
endpackage

// File: rtl/mbox_param_ram.sv
module mbox_param_ram #(
  parameter int AW = 6,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 2 ** AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/mbox_input_sampler.sv
module mbox_input_sampler #(
  parameter int W      = 8,
  parameter int PERIOD = 5000
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic         tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  logic [W-1:0]  sync1, sync2;
  logic [CW-1:0] cnt;

  assign tick = (cnt == CW'(PERIOD - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      sync1 <= '0;
      sync2 <= '0;
      cnt   <= '0;
      dout  <= '0;
    end else begin
      sync1 <= din;
      sync2 <= sync1;
      cnt   <= tick ? '0 : cnt + 1'b1;
      if (tick) dout <= sync2;
    end
  end
endmodule

// File: rtl/mbox_responder.sv
module mbox_responder
  import mbox_pkg::*;
#(
  parameter int          IN_W          = 8,
  parameter int          LATENCY       = 4,
  parameter int          SAMPLE_CYCLES = 5000,
  parameter int          CFG_BASE      = 16,
  parameter int          CFG_AW        = 6,
  parameter logic [15:0] FW_VERSION    = 16'h0102,
  parameter logic [15:0] HW_VERSION    = 16'h0003
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            host_wr_en,
  input  logic [1:0]      host_wr_addr,
  input  logic [7:0]      host_wr_data,
  input  logic [IN_W-1:0] din_raw,
  output logic [7:0]      dout,
  output logic [7:0]      ib_fb_lo,
  output logic [7:0]      ib_fb_hi,
  output logic [7:0]      ib_echo,
  output logic [IN_W-1:0] ib_din
);
  localparam int CNT_W   = $clog2(LATENCY + 1);
  localparam int CFG_END = CFG_BASE + 2 ** CFG_AW;

  logic [7:0]       stage_lo, stage_hi;
  logic [7:0]       cmd_q;
  logic [15:0]      par_q;
  logic             busy;
  logic [CNT_W-1:0] cnt;
  logic             accept, first, done;
  logic [15:0]      next_fb;
  logic [15:0]      ram_rdata;
  logic             sample_tick;
  op_kind_e         kind, tgt_kind;

  function automatic logic in_cfg(input logic [7:0] c);
    return (int'(c) >= CFG_BASE) && (int'(c) < CFG_END);
  endfunction

  function automatic logic [CFG_AW-1:0] cfg_idx(input logic [7:0] c);
    return CFG_AW'(c - 8'(CFG_BASE));
  endfunction

  assign accept = host_wr_en && (host_wr_addr == 2'd2);
  assign first  = busy && (cnt == CNT_W'(LATENCY - 1)) && !accept;
  assign done   = busy && (cnt == '0) && !accept;

  // staging of argument bytes; address 3 is ignored
  always_ff @(posedge clk) begin
    if (rst) begin
      stage_lo <= '0;
      stage_hi <= '0;
    end else if (host_wr_en) begin
      if (host_wr_addr == 2'd0) stage_lo <= host_wr_data;
      if (host_wr_addr == 2'd1) stage_hi <= host_wr_data;
    end
  end

  // command latch and completion timer
  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q <= '0;
      par_q <= '0;
      busy  <= 1'b0;
      cnt   <= '0;
    end else if (accept) begin
      cmd_q <= host_wr_data;
      par_q <= {stage_hi, stage_lo};
      busy  <= 1'b1;
      cnt   <= CNT_W'(LATENCY - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  mbox_param_ram #(.AW(CFG_AW), .DW(16)) u_store (
    .clk   (clk),
    .we    (first && in_cfg(cmd_q)),
    .waddr (cfg_idx(cmd_q)),
    .wdata (par_q),
    .raddr (cfg_idx(par_q[7:0])),
    .rdata (ram_rdata)
  );

  assign kind     = classify(cmd_q);
  assign tgt_kind = classify(par_q[7:0]);

  always_comb begin
    next_fb = '0;
    case (kind)
      K_SET_OUT: next_fb = {8'h00, par_q[7:0]};
      K_GET_OUT: next_fb = {8'h00, dout};
      K_FW:      next_fb = FW_VERSION;
      K_HW:      next_fb = HW_VERSION;
      K_STATUS: begin
        if (in_cfg(par_q[7:0]))
          next_fb = ram_rdata;
        else if (tgt_kind == K_SET_OUT || tgt_kind == K_GET_OUT)
          next_fb = {8'h00, dout};
      end
      default:   next_fb = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ib_echo  <= '0;
      ib_fb_lo <= '0;
      ib_fb_hi <= '0;
      dout     <= '0;
    end else if (done) begin
      ib_echo  <= cmd_q;
      ib_fb_lo <= next_fb[7:0];
      ib_fb_hi <= next_fb[15:8];
      if (kind == K_SET_OUT) dout <= par_q[7:0];
    end
  end

  mbox_input_sampler #(.W(IN_W), .PERIOD(SAMPLE_CYCLES)) u_sampler (
    .clk  (clk),
    .rst  (rst),
    .din  (din_raw),
    .dout (ib_din),
    .tick (sample_tick)
  );
endmodule

// File: rtl/mbox_responder_chk.sv
module mbox_responder_chk #(
  parameter int          IN_W       = 8,
  parameter int          LATENCY    = 4,
  parameter logic [15:0] FW_VERSION = 16'h0102
) (
  input logic            clk,
  input logic            rst,
  input logic            accept,
  input logic            done,
  input logic [7:0]      cmd_q,
  input logic [7:0]      dout,
  input logic [7:0]      ib_echo,
  input logic [7:0]      ib_fb_lo,
  input logic [7:0]      ib_fb_hi,
  input logic [IN_W-1:0] ib_din,
  input logic            sample_tick
);
  logic [15:0] since;

  always_ff @(posedge clk) begin
    if (rst)                  since <= '0;
    else if (accept)          since <= '0;
    else if (since != 16'hFFFF) since <= since + 1'b1;
  end

  AST_LATENCY_EXACT: assert property (@(posedge clk) disable iff (rst)
    done |-> (int'(since) == LATENCY - 1)); // R2
  AST_ECHO_MATCH: assert property (@(posedge clk) disable iff (rst)
    done |=> (ib_echo == $past(cmd_q))); // R2
  AST_ECHO_HOLD: assert property (@(posedge clk) disable iff (rst)
    !done |=> ($stable(ib_echo) && $stable(ib_fb_lo) && $stable(ib_fb_hi))); // R2
  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(done && cmd_q == 8'h01) |=> $stable(dout)); // R4
  AST_FW_REPLY: assert property (@(posedge clk) disable iff (rst)
    (done && cmd_q == 8'h0E) |=> ({ib_fb_hi, ib_fb_lo} == FW_VERSION)); // R6
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    (done && cmd_q == 8'h00) |=> (ib_echo == 8'h00 && {ib_fb_hi, ib_fb_lo} == 16'h0)); // R9
  AST_DIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    !sample_tick |=> $stable(ib_din)); // R11
endmodule

bind mbox_responder mbox_responder_chk #(
  .IN_W(IN_W), .LATENCY(LATENCY), .FW_VERSION(FW_VERSION)
) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .done(done), .cmd_q(cmd_q),
  .dout(dout), .ib_echo(ib_echo), .ib_fb_lo(ib_fb_lo), .ib_fb_hi(ib_fb_hi),
  .ib_din(ib_din), .sample_tick(sample_tick)
);

// File: tb/mbox_responder_tb_top.sv
module mbox_responder_tb_top;
  localparam int          L    = 4;
  localparam int          SAMP = 16;
  localparam logic [15:0] FWV  = 16'h0102;
  localparam logic [15:0] HWV  = 16'h0003;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_wr_en = 1'b0;
  logic [1:0] host_wr_addr = '0;
  logic [7:0] host_wr_data = '0;
  logic [7:0] din_raw = 8'h3C;
  logic [7:0] dout, ib_fb_lo, ib_fb_hi, ib_echo, ib_din;

  always #10 clk = ~clk;

  mbox_responder #(
    .IN_W(8), .LATENCY(L), .SAMPLE_CYCLES(SAMP), .CFG_BASE(16), .CFG_AW(6),
    .FW_VERSION(FWV), .HW_VERSION(HWV)
  ) dut_i (
    .clk(clk), .rst(rst), .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr),
    .host_wr_data(host_wr_data), .din_raw(din_raw), .dout(dout),
    .ib_fb_lo(ib_fb_lo), .ib_fb_hi(ib_fb_hi), .ib_echo(ib_echo), .ib_din(ib_din)
  );

  typedef struct {
    logic [7:0]  code;
    logic [7:0]  prev_echo;
    logic [15:0] fb;
    string       req;
  } exp_t;

  exp_t       sb_q[$];
  exp_t       cur;
  event       go_ev;
  logic       mon_busy = 1'b0;
  logic [7:0] last_echo = 8'h00;
  int         n_chk = 0;
  int         n_fail = 0;

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr_en = 1'b1; host_wr_addr = a; host_wr_data = d;
    @(negedge clk);
    host_wr_en = 1'b0;
  endtask

  // driver: pushes the expected reply, issues the command
  task automatic send(input logic [7:0] code, input logic [15:0] arg,
                      input logic [15:0] fb, input string req, input bit clobber);
    exp_t e;
    wr(2'd0, arg[7:0]);
    wr(2'd1, arg[15:8]);
    e.code = code; e.prev_echo = last_echo; e.fb = fb; e.req = req;
    sb_q.push_back(e);
    mon_busy = 1'b1;
    wr(2'd2, code);
    -> go_ev;
    if (clobber) begin
      wr(2'd0, 8'hFF);
      wr(2'd1, 8'hEE);
      wr(2'd3, 8'h77);
    end
    wait (!mon_busy);
    last_echo = code;
  endtask

  // monitor: pops the expected item and compares at completion
  initial begin
    forever begin
      @(go_ev);
      cur = sb_q.pop_front();
      repeat (L - 1) @(negedge clk);
      chk(cur.req, "echo before completion", {24'h0, ib_echo}, {24'h0, cur.prev_echo});
      @(negedge clk);
      chk(cur.req, "echo/reply", {8'h0, ib_echo, ib_fb_hi, ib_fb_lo},
          {8'h0, cur.code, cur.fb});
      mon_busy = 1'b0;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    // R1 reset state
    chk("R1", "echo", {24'h0, ib_echo}, 32'h0);
    chk("R1", "reply", {16'h0, ib_fb_hi, ib_fb_lo}, 32'h0);
    chk("R1", "dout", {24'h0, dout}, 32'h0);
    chk("R1", "din mirror", {24'h0, ib_din}, 32'h0);

    send(8'h01, 16'h125A, 16'h005A, "R4", 1'b0);
    chk("R4", "dout after set", {24'h0, dout}, 32'h5A);
    send(8'h02, 16'h0000, 16'h005A, "R5", 1'b0);
    chk("R5", "dout after get", {24'h0, dout}, 32'h5A);
    // repeated identical command separated by clear
    send(8'h00, 16'h0000, 16'h0000, "R9", 1'b0);
    send(8'h02, 16'h0000, 16'h005A, "R9", 1'b0);
    send(8'h0E, 16'h0000, FWV, "R6", 1'b0);
    send(8'h0F, 16'h0000, HWV, "R6", 1'b0);
    // table writes, first and last entries
    send(8'h10, 16'h1234, 16'h0000, "R7", 1'b0);
    send(8'h4F, 16'hBEEF, 16'h0000, "R7", 1'b0);
    send(8'h2B, 16'hA55A, 16'h0000, "R7", 1'b0);
    send(8'h07, 16'h0010, 16'h1234, "R8", 1'b0);
    send(8'h07, 16'h004F, 16'hBEEF, "R8", 1'b0);
    send(8'h00, 16'h0000, 16'h0000, "R9", 1'b0);
    send(8'h07, 16'h002B, 16'hA55A, "R8", 1'b0);
    send(8'h00, 16'h0000, 16'h0000, "R9", 1'b0);
    send(8'h07, 16'h0001, 16'h005A, "R8", 1'b0);
    send(8'h00, 16'h0000, 16'h0000, "R9", 1'b0);
    send(8'h07, 16'h0050, 16'h0000, "R8", 1'b0);
    // unknown codes
    send(8'h61, 16'hFFFF, 16'h0000, "R10", 1'b0);
    send(8'h03, 16'h1111, 16'h0000, "R10", 1'b0);
    // argument overwritten during execution, and a byte 3 write
    send(8'h01, 16'h00C3, 16'h00C3, "R3", 1'b1);
    chk("R3", "dout keeps latched argument", {24'h0, dout}, 32'hC3);
    chk("R3", "echo after byte 3 write", {24'h0, ib_echo}, 32'h01);
    send(8'h02, 16'h0000, 16'h00C3, "R3", 1'b0);
    // input mirror
    din_raw = 8'hA5;
    repeat (2 * SAMP + 4) @(negedge clk);
    chk("R11", "din mirror", {24'h0, ib_din}, 32'hA5);
    din_raw = 8'h5A;
    repeat (2 * SAMP + 4) @(negedge clk);
    chk("R11", "din mirror", {24'h0, ib_din}, 32'h5A);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule